// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

The block copies data from a source region to a destination region of a memory port, one unit at a time. Software programs a source address, a destination address and a count of units through a small register interface, chooses the unit width and whether each address steps or stays fixed, and then sets the channel enable. Each unit is a read from the source followed by a write to the destination, with only one access outstanding at any time.

A global operation register gates every transfer. It carries a master enable and two sticky stop flags: one raised by an external non-maskable event input and one raised when a unit's address is not aligned to the unit width. While either flag is set, or the master enable is low, no access is made. Completion is signalled by a sticky end flag in the control word and, when enabled, by a level interrupt. A channel-clear register discards a half-finished unit so that the next access re-reads the current source.

Register offsets: source 0x00, destination 0x04, count 0x08, control 0x0C, operation 0x40, channel clear 0x48.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the control register reads 0x000000D0 (both addresses incrementing, 4-byte units), source, destination, count and operation registers read 0, irq_o and mem_req_o are 0.
- R2: Control word bits: 0 enable, 1 end flag, 2 interrupt enable, 4:3 low size bits, 5 high size bit, 6 source increment, 7 destination increment. The channel is busy when enable is 1 and the end flag is 0. While busy and the operation register allows transfers, writes to the source, destination, count and control registers are ignored.
- R3: Accesses are made only while the channel is busy, the master enable (operation bit 0) is 1 and both stop flags are 0. Each unit reads the source, then writes the read data to the destination; with the master enable low, no access is made.
- R4: The size index is {control bit 5, control bits 4:3}; index 0 selects 1-byte, 1 selects 2-byte and 2 selects 4-byte units, and any index from 3 to 7 acts as index 0. mem_size_o carries log2 of the unit size.
- R5: After each unit's write completes, each address whose increment bit is set advances by the unit size (the other stays fixed) and the count drops by one; at the end the source register holds the start source plus count times unit size.
- R6: One cycle after the count is zero on a busy, allowed channel, the end flag is set without any access (also when a transfer is started with count 0); irq_o is 1 while the end flag and the interrupt enable are both 1.
- R7: Writing 0 to the end flag clears it, writing 1 leaves it unchanged.
- R8: A unit whose source or destination address is not a multiple of the unit size makes no access and sets the address-error flag (operation bit 2); the end flag stays 0.
- R9: A high nmi_i sets the event flag (operation bit 1) and stops all accesses. Each stop flag is cleared only by writing 0 to it (writing 1 keeps it); with both clear and the master enable 1, the transfer resumes where it stopped.
- R10: A write of 0 to the channel-clear register (default variant; a parameter selects instead a write with a chosen bit set) discards a read that has not yet been written, so the next access is a read of the current source address.
- R11: The count register is 24 bits wide: a write of 0xFFFFFFFF reads back as 0x00FFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset, used for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| nmi_i | input | 1 | Non-maskable stop event |
| irq_o | output | 1 | Completion interrupt |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_size_o | output | 2 | log2 of the access width in bytes |
| mem_wdata_o | output | 32 | Write data, right-justified |
| mem_ack_i | input | 1 | Access completes in this cycle |
| mem_rdata_i | input | 32 | Read data, right-justified, valid with mem_ack_i |

## Verification
On every cycle the assertions check that requests appear only on a busy, allowed channel, that every request address is aligned to the unit width, that a completed read is never followed by another read without a clear, that the count never rises while the channel is locked, that the end flag only rises at count zero and that an address error never coincides with the end flag. The bench's scenarios alone show the data actually copied for each size and increment mode, the size index folding, the final address values, the write lock, the clear-by-zero flag semantics, stopping and resuming around an external event, and the discarded half unit after a channel clear.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_AW = 7;

  localparam logic [REG_AW-1:0] OFS_SRC = 7'h00;
  localparam logic [REG_AW-1:0] OFS_DST = 7'h04;
  localparam logic [REG_AW-1:0] OFS_CNT = 7'h08;
  localparam logic [REG_AW-1:0] OFS_CTL = 7'h0C;
  localparam logic [REG_AW-1:0] OFS_OPR = 7'h40;
  localparam logic [REG_AW-1:0] OFS_CLR = 7'h48;

  localparam int CTL_TE  = 1;
  localparam int OPR_DME = 0;
  localparam int OPR_NMI = 1;
  localparam int OPR_AE  = 2;

  typedef struct packed {
    logic       dst_inc;
    logic       src_inc;
    logic       sz_hi;
    logic [1:0] sz_lo;
    logic       ie;
    logic       te;
    logic       en;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{dst_inc: 1'b1, src_inc: 1'b1, sz_hi: 1'b0,
                                 sz_lo: 2'b10, ie: 1'b0, te: 1'b0, en: 1'b0};

  // unsupported indices fold to index 0
  function automatic logic [1:0] unit_log2(input logic [2:0] idx);
    case (idx)
      3'd1:    unit_log2 = 2'd1;
      3'd2:    unit_log2 = 2'd2;
      default: unit_log2 = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter bit CLR_BITWISE = 1'b0,
  parameter int CLR_BIT     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              nmi_i,
  input  logic              unit_done_i,
  input  logic              set_te_i,
  input  logic              set_ae_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [1:0]        log2_o,
  output logic              busy_o,
  output logic              run_o,
  output logic              clr_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] src_q, dst_q, step;
  logic [CNT_W-1:0]  cnt_q;
  ctl_t              ctl_q;
  logic              dme_q, nmif_q, ae_q;
  logic              locked;

  assign log2_o = unit_log2({ctl_q.sz_hi, ctl_q.sz_lo});
  assign step   = ADDR_W'(1) << log2_o;
  assign busy_o = ctl_q.en & ~ctl_q.te;
  assign run_o  = dme_q & ~nmif_q & ~ae_q;
  assign locked = busy_o & run_o;
  assign irq_o  = ctl_q.te & ctl_q.ie;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;

  generate
    if (CLR_BITWISE) begin : g_clr_bit
      assign clr_o = wr_i && (addr_i == OFS_CLR) && wdata_i[CLR_BIT];
    end else begin : g_clr_zero
      assign clr_o = wr_i && (addr_i == OFS_CLR) && (wdata_i == '0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctl_q  <= CTL_RESET;
      dme_q  <= 1'b0;
      nmif_q <= 1'b0;
      ae_q   <= 1'b0;
    end else begin
      if (wr_i && !locked) begin
        case (addr_i)
          OFS_SRC: src_q <= ADDR_W'(wdata_i);
          OFS_DST: dst_q <= ADDR_W'(wdata_i);
          OFS_CNT: cnt_q <= wdata_i[CNT_W-1:0];
          OFS_CTL: begin
            ctl_q    <= ctl_t'(wdata_i[7:0]);
            ctl_q.te <= ctl_q.te & wdata_i[CTL_TE];
          end
          default: ;
        endcase
      end
      if (unit_done_i) begin
        src_q <= src_q + (ctl_q.src_inc ? step : '0);
        dst_q <= dst_q + (ctl_q.dst_inc ? step : '0);
        cnt_q <= cnt_q - 1'b1;
      end
      if (set_te_i) ctl_q.te <= 1'b1;
      if (wr_i && addr_i == OFS_OPR) begin
        dme_q  <= wdata_i[OPR_DME];
        nmif_q <= nmif_q & wdata_i[OPR_NMI];
        ae_q   <= ae_q & wdata_i[OPR_AE];
      end
      if (nmi_i)    nmif_q <= 1'b1;
      if (set_ae_i) ae_q   <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_SRC: rdata_o = DATA_W'(src_q);
      OFS_DST: rdata_o = DATA_W'(dst_q);
      OFS_CNT: rdata_o = DATA_W'(cnt_q);
      OFS_CTL: rdata_o = DATA_W'(ctl_q);
      OFS_OPR: rdata_o = DATA_W'({ae_q, nmif_q, dme_q});
      default: ;
    endcase
  end

  assert_te_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.te) |-> $past(cnt_q == '0));
  assert_cnt_falls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && $past(locked)) |-> (cnt_q <= $past(cnt_q)));
  assert_ae_without_te_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ae_q) |-> !ctl_q.te);
endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        log2_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              unit_done_o,
  output logic              set_te_o,
  output logic              set_ae_o
);
  localparam int LANES = DATA_W / 8;

  logic              wr_q;
  logic [DATA_W-1:0] buf_q, lane_mask;
  logic [ADDR_W-1:0] amask;
  logic              active, misalign;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{32'(b) < (32'd1 << log2_i)}};
  end

  assign amask    = (ADDR_W'(1) << log2_i) - 1'b1;
  assign misalign = |((src_i | dst_i) & amask);
  assign active   = busy_i & run_i & (cnt_i != '0);

  assign set_ae_o    = active & ~wr_q & misalign;
  assign mem_req_o   = active & ~(~wr_q & misalign);
  assign mem_we_o    = wr_q;
  assign mem_addr_o  = wr_q ? dst_i : src_i;
  assign mem_size_o  = log2_i;
  assign mem_wdata_o = buf_q;
  assign unit_done_o = mem_req_o & mem_ack_i & wr_q;
  assign set_te_o    = busy_i & run_i & (cnt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      buf_q <= '0;
    end else if (clr_i) begin
      wr_q  <= 1'b0;
      buf_q <= '0;
    end else if (mem_req_o && mem_ack_i) begin
      wr_q <= ~wr_q;
      if (!wr_q) buf_q <= mem_rdata_i & lane_mask;
    end
  end

  assert_req_when_allowed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (busy_i && run_i));
  assert_read_then_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_we_o && !clr_i) |=> !(mem_req_o && !mem_we_o));
  assert_aligned_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o & amask) == '0));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter bit CLR_BITWISE = 1'b0,
  parameter int CLR_BIT     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              nmi_i,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [ADDR_W-1:0] src, dst;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        log2;
  logic busy, run, clr, unit_done, set_te, set_ae;

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CLR_BITWISE(CLR_BITWISE), .CLR_BIT(CLR_BIT)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .nmi_i, .unit_done_i(unit_done), .set_te_i(set_te), .set_ae_i(set_ae),
    .src_o(src), .dst_o(dst), .cnt_o(cnt), .log2_o(log2),
    .busy_o(busy), .run_o(run), .clr_o(clr), .irq_o
  );

  dma_chan_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_xfer (
    .clk_i, .rst_ni,
    .busy_i(busy), .run_i(run), .clr_i(clr),
    .src_i(src), .dst_i(dst), .cnt_i(cnt), .log2_i(log2),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_size_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i,
    .unit_done_o(unit_done), .set_te_o(set_te), .set_ae_o(set_ae)
  );
endmodule

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
  localparam logic [6:0] A_SRC = 7'h00, A_DST = 7'h04, A_CNT = 7'h08,
                         A_CTL = 7'h0C, A_OPR = 7'h40, A_CLR = 7'h48;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [23:0] cnt;
    logic [2:0]  idx;
    logic        si;
    logic        di;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{src: 32'h10, dst: 32'h80, cnt: 24'd4, idx: 3'd2, si: 1'b1, di: 1'b1},
    '{src: 32'h21, dst: 32'h91, cnt: 24'd5, idx: 3'd0, si: 1'b1, di: 1'b1},
    '{src: 32'h30, dst: 32'hA0, cnt: 24'd3, idx: 3'd1, si: 1'b1, di: 1'b0},
    '{src: 32'h40, dst: 32'hB1, cnt: 24'd3, idx: 3'd5, si: 1'b1, di: 1'b1},
    '{src: 32'h44, dst: 32'hC4, cnt: 24'd2, idx: 3'd2, si: 1'b0, di: 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi = 1'b0;
  logic        irq;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        rdy = 1'b1;

  logic [7:0]  mem_b  [256];
  logic [7:0]  shadow [256];
  int unsigned acc_cnt = 0;
  int unsigned cyc = 0;
  int checks = 0, fails = 0;
  bit  done_flag = 1'b0;

  always #2 clk = ~clk;

  dma_chan_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .nmi_i(nmi), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  assign mem_ack = mem_req & rdy;

  always_comb begin
    mem_rdata = {mem_b[8'(mem_addr[7:0] + 8'd3)], mem_b[8'(mem_addr[7:0] + 8'd2)],
                 mem_b[8'(mem_addr[7:0] + 8'd1)], mem_b[mem_addr[7:0]]};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_b[i] <= 8'(i * 7 + 3);
    end else if (mem_req && mem_ack) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (k < (1 << mem_size)) mem_b[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_te();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_read(A_CTL, v);
      if (v[1]) break;
    end
  endtask

  function automatic logic [1:0] exp_log2(input logic [2:0] idx);
    return (idx == 3'd1) ? 2'd1 : (idx == 3'd2) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [31:0] ctl_word(input logic [2:0] idx, input logic si,
                                           input logic di, input logic ie, input logic en);
    return {24'd0, di, si, idx[2], idx[1:0], ie, 1'b0, en};
  endfunction

  task automatic ref_copy(input logic [31:0] s, input logic [31:0] d, input int n,
                          input logic [1:0] l2, input logic si, input logic di);
    logic [7:0] s8, d8;
    s8 = s[7:0]; d8 = d[7:0];
    for (int u = 0; u < n; u++) begin
      for (int k = 0; k < (1 << l2); k++) shadow[8'(d8 + 8'(k))] = shadow[8'(s8 + 8'(k))];
      if (si) s8 = 8'(s8 + (8'd1 << l2));
      if (di) d8 = 8'(d8 + (8'd1 << l2));
    end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem_b[i] !== shadow[i]) n++;
    return n;
  endfunction

  initial begin
    logic [31:0] v;
    logic [1:0]  l2;
    int unsigned a0;
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_read(A_CTL, v); check("R1 ctl", v, 32'hD0);
    reg_read(A_SRC, v); check("R1 src", v, 32'h0);
    reg_read(A_CNT, v); check("R1 cnt", v, 32'h0);
    reg_read(A_OPR, v); check("R1 opr", v, 32'h0);
    check("R1 irq/req", {30'd0, irq, mem_req}, 32'h0);

    // R11: count width
    reg_write(A_CNT, 32'hFFFF_FFFF);
    reg_read(A_CNT, v); check("R11 cnt mask", v, 32'h00FF_FFFF);

    // R3: master enable low blocks accesses
    reg_write(A_SRC, 32'h08); reg_write(A_DST, 32'h68); reg_write(A_CNT, 32'd2);
    ref_copy(32'h08, 32'h68, 2, 2'd2, 1'b1, 1'b1);
    a0 = acc_cnt;
    reg_write(A_CTL, ctl_word(3'd2, 1'b1, 1'b1, 1'b0, 1'b1));
    repeat (6) @(negedge clk);
    #1 check("R3 no access without DME", acc_cnt - a0, 32'd0);
    reg_write(A_OPR, 32'h1);
    wait_te();
    reg_read(A_SRC, v); check("R3 resumed src", v, 32'h10);
    check("R3 data copied", mem_diff(), 32'd0);
    reg_write(A_CTL, 32'h0);

    // vector table: R4, R5, R6
    foreach (VECS[i]) begin
      l2 = exp_log2(VECS[i].idx);
      reg_write(A_SRC, VECS[i].src);
      reg_write(A_DST, VECS[i].dst);
      reg_write(A_CNT, 32'(VECS[i].cnt));
      ref_copy(VECS[i].src, VECS[i].dst, int'(VECS[i].cnt), l2, VECS[i].si, VECS[i].di);
      reg_write(A_CTL, ctl_word(VECS[i].idx, VECS[i].si, VECS[i].di, 1'b1, 1'b1));
      wait_te();
      reg_read(A_SRC, v);
      check("R5 final src", v, VECS[i].src + (VECS[i].si ? (32'(VECS[i].cnt) << l2) : 32'd0));
      reg_read(A_DST, v);
      check("R4 final dst", v, VECS[i].dst + (VECS[i].di ? (32'(VECS[i].cnt) << l2) : 32'd0));
      reg_read(A_CNT, v); check("R5 count zero", v, 32'd0);
      check("R6 irq at end", {31'd0, irq}, 32'd1);
      check("R5 memory image", mem_diff(), 32'd0);
      reg_write(A_CTL, 32'h0);
    end

    // R6 count zero start, R7 end flag semantics
    a0 = acc_cnt;
    reg_write(A_CNT, 32'd0);
    reg_write(A_CTL, ctl_word(3'd2, 1'b1, 1'b1, 1'b1, 1'b1));
    repeat (2) @(negedge clk);
    reg_read(A_CTL, v); check("R6 te on zero count", {31'd0, v[1]}, 32'd1);
    check("R6 no access on zero count", acc_cnt - a0, 32'd0);
    check("R6 irq", {31'd0, irq}, 32'd1);
    reg_write(A_CTL, ctl_word(3'd2, 1'b1, 1'b1, 1'b1, 1'b1) | 32'h2);
    reg_read(A_CTL, v); check("R7 write 1 keeps te", {31'd0, v[1]}, 32'd1);
    reg_write(A_CTL, ctl_word(3'd2, 1'b1, 1'b1, 1'b1, 1'b0));
    reg_read(A_CTL, v); check("R7 write 0 clears te", {31'd0, v[1]}, 32'd0);
    check("R6 irq low after clear", {31'd0, irq}, 32'd0);

    // R2: writes ignored while locked
    rdy = 1'b0;
    reg_write(A_SRC, 32'h60); reg_write(A_DST, 32'hE0); reg_write(A_CNT, 32'd2);
    ref_copy(32'h60, 32'hE0, 2, 2'd2, 1'b1, 1'b1);
    reg_write(A_CTL, ctl_word(3'd2, 1'b1, 1'b1, 1'b0, 1'b1));
    reg_write(A_SRC, 32'h1234_5678);
    reg_read(A_SRC, v); check("R2 src locked", v, 32'h60);
    reg_write(A_CTL, 32'h0);
    reg_read(A_CTL, v); check("R2 ctl locked", {30'd0, v[1:0]}, 32'd1);
    rdy = 1'b1;
    wait_te();
    reg_read(A_SRC, v); check("R2 src after run", v, 32'h68);
    reg_write(A_CTL, 32'h0);

    // R8: misaligned unit
    a0 = acc_cnt;
    reg_write(A_SRC, 32'h12); reg_write(A_DST, 32'h80); reg_write(A_CNT, 32'd2);
    reg_write(A_CTL, ctl_word(3'd2, 1'b1, 1'b1, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    reg_read(A_OPR, v); check("R8 ae set", v, 32'h5);
    reg_read(A_CTL, v); check("R8 te stays low", {30'd0, v[1:0]}, 32'd1);
    check("R8 no access", acc_cnt - a0, 32'd0);
    reg_write(A_CTL, 32'h0);
    reg_write(A_OPR, 32'h1);
    reg_read(A_OPR, v); check("R8 ae cleared by 0", v, 32'h1);

    // R9: external stop event
    reg_write(A_SRC, 32'h00); reg_write(A_DST, 32'h70); reg_write(A_CNT, 32'd8);
    ref_copy(32'h00, 32'h70, 8, 2'd0, 1'b1, 1'b1);
    reg_write(A_CTL, ctl_word(3'd0, 1'b1, 1'b1, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    reg_read(A_OPR, v); check("R9 event flag", v, 32'h3);
    a0 = acc_cnt;
    repeat (10) @(negedge clk);
    #1 check("R9 stopped", acc_cnt - a0, 32'd0);
    reg_write(A_OPR, 32'h3);
    reg_read(A_OPR, v); check("R9 write 1 keeps flag", v, 32'h3);
    reg_write(A_OPR, 32'h1);
    wait_te();
    reg_read(A_SRC, v); check("R9 resumed src", v, 32'h08);
    reg_read(A_DST, v); check("R9 resumed dst", v, 32'h78);
    check("R9 memory image", mem_diff(), 32'd0);
    reg_write(A_CTL, 32'h0);

    // R10: channel clear discards a half unit
    rdy = 1'b0;
    reg_write(A_SRC, 32'h50); reg_write(A_DST, 32'hD0); reg_write(A_CNT, 32'd2);
    ref_copy(32'h50, 32'hD0, 2, 2'd2, 1'b1, 1'b1);
    reg_write(A_CTL, ctl_word(3'd2, 1'b1, 1'b1, 1'b0, 1'b1));
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    #1 check("R10 write pending", {30'd0, mem_req, mem_we}, 32'd3);
    reg_write(A_OPR, 32'h0);
    reg_write(A_CLR, 32'h0);
    reg_write(A_OPR, 32'h1);
    #1 check("R10 re-read after clear", {mem_addr[30:0], mem_we}, {31'h50, 1'b0});
    check("R10 request present", {31'd0, mem_req}, 32'd1);
    rdy = 1'b1;
    wait_te();
    reg_read(A_SRC, v); check("R10 final src", v, 32'h58);
    check("R10 memory image", mem_diff(), 32'd0);
    reg_write(A_CTL, 32'h0);

    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule